// File: doc/BRIEF.md
# Window Watchdog with Lead Time

This block supervises a host controller by demanding periodic trigger events inside a timed window. All timing runs on a slow oscillator tick, a one-cycle enable strobe in the system clock domain. When the block is enabled it opens a long lead phase in which the first trigger must arrive. Each accepted trigger then starts a closed window, in which a trigger is forbidden, followed by an open window, in which a trigger is expected.

A trigger is a rising edge on the positive trigger input or a falling edge on the negative trigger input. The new level must be held for a programmable number of system clocks, so short glitches are rejected. A trigger that arrives too early, or no trigger by the end of a window, raises the reset request for a fixed number of ticks. After that the lead phase starts again. The mode controller drives the enable input. While the enable is low the watchdog rests idle, and raising the enable again always restarts the lead phase.

Top module: `wdg_window_top`

## Requirements
- R1: After the block is enabled, or after a reset pulse ends, a lead phase of LEAD_TICKS ticks (default 3922) begins. If no trigger arrives in it, rst_req_o goes high at its end.
- R2: A trigger accepted during the lead phase starts a closed window of CLOSED_TICKS ticks (default 800). No reset request follows it.
- R3: A trigger accepted during the closed window raises rst_req_o exactly one clock after the trigger is recognised. Recognition happens MIN_W+2 clock edges after the input first shows the new level, so rst_req_o is high after MIN_W+3 edges and low after MIN_W+2.
- R4: An open window of OPEN_TICKS ticks (default 840) follows the closed window. A trigger accepted in it starts a new closed window.
- R5: If no trigger arrives before the open window ends, rst_req_o goes high.
- R6: A reset request stays high for RST_TICKS ticks (default 157). After it falls, a new lead phase begins.
- R7: A trigger is a rising edge on ptrig_i (idle 0) or a falling edge on ntrig_i (idle 1). The new level must be sampled on at least MIN_W consecutive clock edges. A level held for MIN_W-1 edges is ignored.
- R8: While en_i is low the block is idle and rst_req_o is low, and triggers have no effect. A rising en_i starts a lead phase.
- R9: Triggers that arrive while rst_req_o is high are ignored, and the pulse keeps its full RST_TICKS length.
- R10: After rst_n is released with en_i low, rst_req_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle oscillator tick strobe |
| en_i | input | 1 | Watchdog enable from the mode controller |
| ptrig_i | input | 1 | Trigger input, active on a rising edge |
| ntrig_i | input | 1 | Trigger input, active on a falling edge |
| rst_req_o | output | 1 | Watchdog reset request, active high |

## Verification
A trigger becomes an internal event MIN_W+2 clock edges after the input level changes, and the early-trigger reset appears one edge later. That path is checked on its exact edge, both the cycle before and the cycle it is due. Window and pulse ends fall on a tick, and the free-running tick is out of phase with the stimulus by up to one tick. Those checks therefore sample at least ten ticks clear of each boundary, and pulse lengths are accepted within one tick of RST_TICKS. Every sample is taken on the falling clock edge.

// File: rtl/wdg_pkg.sv
// Package: shared phase encoding and helpers for the window watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package wdg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LEAD   = 3'd1,
        PH_CLOSED = 3'd2,
        PH_OPEN   = 3'd3,
        PH_RST    = 3'd4
    } wdg_phase_e;

    // Largest of four counts, used to size the shared phase counter.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/wdg_edge_qual.sv
// Module: wdg_edge_qual
// Brings one trigger input into the clock domain with two flops. It accepts
// a level change only after the new level is seen on MIN_W consecutive
// edges. It gives a one-cycle pulse when the accepted level becomes the
// active one.
// Assumes: the input is asynchronous; ACT_HIGH selects rising (1) or
// falling (0) as the trigger edge; the idle level is !ACT_HIGH.
module wdg_edge_qual #(
    parameter int MIN_W    = 16,
    parameter bit ACT_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic trig_o
);
    localparam int  QW       = (MIN_W < 2) ? 1 : $clog2(MIN_W);
    localparam bit  IDLE_LVL = !ACT_HIGH;

    logic          sync1, sync2;
    logic          qual;
    logic [QW-1:0] run_cnt;

    // Two-flop synchroniser, reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= IDLE_LVL;
            sync2 <= IDLE_LVL;
        end else begin
            sync1 <= lvl_i;
            sync2 <= sync1;
        end
    end

    // Width qualifier: count differing samples, accept the level after MIN_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual    <= IDLE_LVL;
            run_cnt <= '0;
            trig_o  <= 1'b0;
        end else begin
            trig_o <= 1'b0;
            if (sync2 == qual) begin
                run_cnt <= '0;
            end else if (run_cnt == QW'(MIN_W - 1)) begin
                qual    <= sync2;
                run_cnt <= '0;
                trig_o  <= (sync2 == ACT_HIGH);
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R7: a trigger pulse lasts a single clock.
    p_trig_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R7: a trigger only follows a stable active level on the synchroniser.
    p_trig_after_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_o) |-> (qual == ACT_HIGH) && ($past(sync2) == ACT_HIGH));

endmodule

// File: rtl/wdg_win_timer.sv
// Module: wdg_win_timer
// The phase sequencer. It runs idle, lead, closed, open and reset phases on
// the oscillator tick, reacts to qualified triggers and drives the reset
// request.
// Assumes: trig_i is a one-cycle pulse; tick_i is a one-cycle strobe; each
// phase lasts its tick count, and ends on the tick that completes the count.
module wdg_win_timer
    import wdg_pkg::*;
#(
    parameter int LEAD_TICKS   = 3922,
    parameter int CLOSED_TICKS = 800,
    parameter int OPEN_TICKS   = 840,
    parameter int RST_TICKS    = 157
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic en_i,
    input  logic trig_i,
    output logic rst_req_o
);
    localparam int MAX_T = max4(LEAD_TICKS, CLOSED_TICKS, OPEN_TICKS, RST_TICKS);
    localparam int CW    = $clog2(MAX_T + 1);

    wdg_phase_e    phase, nxt_phase;
    logic [CW-1:0] cnt, nxt_cnt, limit;
    logic          last_tick;

    // Tick count of the phase now running.
    always_comb begin
        case (phase)
            PH_LEAD:   limit = CW'(LEAD_TICKS);
            PH_CLOSED: limit = CW'(CLOSED_TICKS);
            PH_OPEN:   limit = CW'(OPEN_TICKS);
            PH_RST:    limit = CW'(RST_TICKS);
            default:   limit = CW'(1);
        endcase
    end

    assign last_tick = tick_i && (cnt == limit - 1'b1);

    // Next phase and count from triggers, ticks and enable.
    always_comb begin
        nxt_phase = phase;
        nxt_cnt   = cnt;
        case (phase)
            PH_IDLE: begin
                nxt_phase = PH_LEAD;
                nxt_cnt   = '0;
            end
            PH_LEAD: begin
                if (trig_i) begin
                    nxt_phase = PH_CLOSED;
                    nxt_cnt   = '0;
                end else if (last_tick) begin
                    nxt_phase = PH_RST;
                    nxt_cnt   = '0;
                end else if (tick_i) begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            PH_CLOSED: begin
                if (trig_i) begin
                    nxt_phase = PH_RST;
                    nxt_cnt   = '0;
                end else if (last_tick) begin
                    nxt_phase = PH_OPEN;
                    nxt_cnt   = '0;
                end else if (tick_i) begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            PH_OPEN: begin
                if (trig_i) begin
                    nxt_phase = PH_CLOSED;
                    nxt_cnt   = '0;
                end else if (last_tick) begin
                    nxt_phase = PH_RST;
                    nxt_cnt   = '0;
                end else if (tick_i) begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            PH_RST: begin
                if (last_tick) begin
                    nxt_phase = PH_LEAD;
                    nxt_cnt   = '0;
                end else if (tick_i) begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            default: begin
                nxt_phase = PH_IDLE;
                nxt_cnt   = '0;
            end
        endcase
        if (!en_i) begin
            nxt_phase = PH_IDLE;
            nxt_cnt   = '0;
        end
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= nxt_phase;
            cnt   <= nxt_cnt;
        end
    end

    assign rst_req_o = (phase == PH_RST);

    // R3: a trigger in the closed window enters the reset phase next clock.
    p_early_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CLOSED) && trig_i && en_i |=> rst_req_o);

    // R9: a trigger during the reset pulse does not shorten it.
    p_rst_ignores_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RST) && trig_i && en_i && !last_tick |=> rst_req_o);

    // R8: a low enable leaves the block idle with no request.
    p_disable_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (phase == PH_IDLE) && !rst_req_o);

    // R8: enabling from idle always opens a lead phase.
    p_enable_lead_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) && en_i |=> (phase == PH_LEAD) && (cnt == '0));

    // R6: the end of the reset pulse leads into a lead phase.
    p_rst_to_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_o) && en_i |-> (phase == PH_LEAD));

    // R1: the counter never reaches the phase limit.
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < limit);

endmodule

// File: rtl/wdg_window_top.sv
// Module: wdg_window_top
// Window watchdog top. Two trigger qualifiers, one per input polarity, feed
// the phase sequencer, which raises the reset request.
// Assumes: tick_i is a one-cycle strobe from a slow oscillator; en_i comes
// from the mode controller; triggers are asynchronous.
module wdg_window_top #(
    parameter int LEAD_TICKS   = 3922,
    parameter int CLOSED_TICKS = 800,
    parameter int OPEN_TICKS   = 840,
    parameter int RST_TICKS    = 157,
    parameter int MIN_W        = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic en_i,
    input  logic ptrig_i,
    input  logic ntrig_i,
    output logic rst_req_o
);
    localparam int NTRIG = 2;

    logic [NTRIG-1:0] trig_lvl;
    logic [NTRIG-1:0] trig_ev;
    logic             trig_any;

    assign trig_lvl = {ntrig_i, ptrig_i};

    // One qualifier per input: index 0 rises to trigger, index 1 falls.
    for (genvar gi = 0; gi < NTRIG; gi++) begin : g_qual
        wdg_edge_qual #(
            .MIN_W    (MIN_W),
            .ACT_HIGH (gi == 0)
        ) i_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (trig_lvl[gi]),
            .trig_o (trig_ev[gi])
        );
    end

    assign trig_any = |trig_ev;

    wdg_win_timer #(
        .LEAD_TICKS   (LEAD_TICKS),
        .CLOSED_TICKS (CLOSED_TICKS),
        .OPEN_TICKS   (OPEN_TICKS),
        .RST_TICKS    (RST_TICKS)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .en_i      (en_i),
        .trig_i    (trig_any),
        .rst_req_o (rst_req_o)
    );

    // R10: right after reset the request is low.
    p_reset_quiet_r10: assert property (@(posedge clk)
        $rose(rst_n) |-> !rst_req_o);

endmodule

// File: tb/test_wdg_window_top.sv
`timescale 1ns/1ps
module test_wdg_window_top;

    localparam int LEAD   = 3922;
    localparam int CLOSED = 800;
    localparam int OPENW  = 840;
    localparam int RSTT   = 157;
    localparam int MIN_W  = 16;
    localparam int DIV    = 2;
    localparam int HOLD   = MIN_W + 4;

    typedef struct packed {
        logic pol;   // 0: ptrig rising, 1: ntrig falling
        int   w1;    // ticks from enable to first trigger
        int   w2;    // ticks from first to second trigger
    } row_t;

    localparam int NROWS = 8;
    localparam row_t ROWS [NROWS] = '{
        '{1'b0, 100,  400},
        '{1'b1, 100,  400},
        '{1'b0, 3800, 900},
        '{1'b1, 2000, 1600},
        '{1'b0, 10,   790},
        '{1'b1, 10,   815},
        '{1'b0, 3000, 30},
        '{1'b1, 500,  1200}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic en = 1'b0;
    logic ptrig = 1'b0;
    logic ntrig = 1'b1;
    logic rst_req;
    int   n_chk = 0;
    int   n_fail = 0;
    int   div_cnt = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    // Free-running tick strobe, one clock in every DIV.
    always @(posedge clk) begin
        div_cnt <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
        tick    <= (div_cnt == DIV - 1);
    end

    wdg_window_top #(
        .LEAD_TICKS(LEAD), .CLOSED_TICKS(CLOSED), .OPEN_TICKS(OPENW),
        .RST_TICKS(RSTT), .MIN_W(MIN_W)
    ) i_wdg_window_top (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en),
        .ptrig_i(ptrig), .ntrig_i(ntrig), .rst_req_o(rst_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    // Drive the active level of one input for h clocks, then return to idle.
    task automatic drive_trig(input bit pol, input int h);
        if (pol) ntrig = 1'b0; else ptrig = 1'b1;
        repeat (h) @(negedge clk);
        ptrig = 1'b0;
        ntrig = 1'b1;
    endtask

    // Trigger, then wait so that n ticks pass from the start of the trigger.
    task automatic trig_wait(input bit pol, input int n);
        drive_trig(pol, HOLD);
        repeat (n * DIV - HOLD) @(negedge clk);
    endtask

    task automatic restart();
        en = 1'b0;
        repeat (2) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
    endtask

    // Count clocks until the request falls; optionally trigger mid-pulse.
    task automatic measure_pulse(input bit poke, output int len);
        len = 0;
        while (rst_req && len < 4 * RSTT * DIV) begin
            ptrig = poke && (len >= 40) && (len < 40 + HOLD);
            @(negedge clk);
            len++;
        end
        ptrig = 1'b0;
    endtask

    task automatic wait_rise(input int lim, output bit seen);
        seen = 1'b0;
        for (int k = 0; k < lim && !seen; k++) begin
            @(negedge clk);
            if (rst_req) seen = 1'b1;
        end
    endtask

    initial begin
        int len;
        bit seen;
        bit exp;
        repeat (4) @(negedge clk);
        check(rst_req == 1'b0, "R10 in reset", rst_req, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(rst_req == 1'b0, "R10 after reset", rst_req, 0);

        // Table: first trigger in lead, second trigger early or in open window.
        for (int r = 0; r < NROWS; r++) begin
            restart();
            wait_ticks(ROWS[r].w1);
            trig_wait(ROWS[r].pol, ROWS[r].w2);
            check(rst_req == 1'b0, "R2 lead trigger accepted", rst_req, 0);
            drive_trig(ROWS[r].pol, HOLD);
            repeat (20) @(negedge clk);
            exp = (ROWS[r].w2 < CLOSED);
            check(rst_req == exp, exp ? "R3 early trigger R7" : "R4 open trigger R7",
                  rst_req, exp);
        end

        // R1: lead phase expiry without a trigger, R6: pulse length and restart.
        restart();
        wait_ticks(LEAD - 10);
        check(rst_req == 1'b0, "R1 before lead end", rst_req, 0);
        wait_rise(40 * DIV, seen);
        check(seen, "R1 reset at lead end", seen, 1);
        measure_pulse(1'b0, len);
        check(len >= (RSTT - 1) * DIV && len <= (RSTT + 1) * DIV, "R6 pulse length",
              len, RSTT * DIV);
        wait_ticks(LEAD - 20);
        check(rst_req == 1'b0, "R6 new lead phase", rst_req, 0);
        wait_rise(40 * DIV, seen);
        check(seen, "R6 second lead expiry", seen, 1);

        // R3: exact cycle of the early-trigger reset.
        restart();
        wait_ticks(50);
        trig_wait(1'b0, 100);
        ptrig = 1'b1;
        repeat (MIN_W + 2) @(negedge clk);
        check(rst_req == 1'b0, "R3 one clock before", rst_req, 0);
        @(negedge clk);
        check(rst_req == 1'b1, "R3 on the due clock", rst_req, 1);
        ptrig = 1'b0;

        // R9: trigger during the pulse is ignored, pulse keeps full length.
        measure_pulse(1'b1, len);
        len = len + 1;
        check(len >= (RSTT - 1) * DIV && len <= (RSTT + 1) * DIV, "R9 pulse unchanged",
              len, RSTT * DIV);
        wait_ticks(LEAD - 30);
        check(rst_req == 1'b0, "R9 lead after pulse", rst_req, 0);

        // R5: no trigger in the open window.
        restart();
        wait_ticks(20);
        trig_wait(1'b1, CLOSED + OPENW - 15);
        check(rst_req == 1'b0, "R5 before open end", rst_req, 0);
        wait_rise(40 * DIV, seen);
        check(seen, "R5 reset at open end", seen, 1);

        // R4: open trigger restarts the closed window (early trigger later).
        restart();
        wait_ticks(20);
        trig_wait(1'b0, 1000);
        trig_wait(1'b1, 1000);
        check(rst_req == 1'b0, "R4 chain of open triggers", rst_req, 0);
        trig_wait(1'b0, 500);
        drive_trig(1'b1, HOLD);
        repeat (20) @(negedge clk);
        check(rst_req == 1'b1, "R4 closed window restarted", rst_req, 1);

        // R7: glitch of MIN_W-1 clocks in the closed window is ignored.
        restart();
        wait_ticks(20);
        trig_wait(1'b0, 100);
        drive_trig(1'b0, MIN_W - 1);
        repeat (40) @(negedge clk);
        check(rst_req == 1'b0, "R7 short positive glitch", rst_req, 0);
        drive_trig(1'b1, MIN_W - 1);
        repeat (40) @(negedge clk);
        check(rst_req == 1'b0, "R7 short negative glitch", rst_req, 0);
        drive_trig(1'b1, MIN_W);
        repeat (20) @(negedge clk);
        check(rst_req == 1'b1, "R7 minimum width accepted", rst_req, 1);

        // R8: disable clears a pulse, triggers while disabled have no effect.
        en = 1'b0;
        repeat (3) @(negedge clk);
        check(rst_req == 1'b0, "R8 disable drops request", rst_req, 0);
        drive_trig(1'b0, HOLD);
        repeat (HOLD) @(negedge clk);
        drive_trig(1'b1, HOLD);
        repeat (HOLD) @(negedge clk);
        check(rst_req == 1'b0, "R8 triggers while disabled", rst_req, 0);
        en = 1'b1;
        wait_ticks(3000);
        check(rst_req == 1'b0, "R8 restart from lead", rst_req, 0);
        wait_rise(960 * DIV, seen);
        check(seen, "R8 lead expiry after enable", seen, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule